// File: doc/BRIEF.md
# Strobe Watchdog With Reset Pulse

This block watches a software strobe and asks for a processor reset when the strobe stops. It counts millisecond ticks from the moment the system reset goes inactive. Every high-to-low transition of the strobe sets the count back to zero. If the count reaches the timeout and no strobe has come, the block raises a reset request for a fixed number of ticks. It then arms itself again with a fresh count.

The strobe arrives from outside the clock domain. It passes through a synchronizer, and edges are detected on the synchronized value. The watchdog is held off, with its count at zero, in four cases:

- the system reset is active;
- the supply is below its trip point;
- an external "strobe floating" indication is set;
- the mode select is in low-power mode and the early-warning sense is low.

In the other mode the early-warning sense does nothing.

Top module: `strobe_watchdog`

## Requirements
- R1: With the watchdog running and no strobe falling edge, `wd_rst_req` rises on the clock edge that samples the TIMEOUT_TICKS-th `tick_ms` pulse counted since arming. It stays low before that tick.
- R2: Once raised, `wd_rst_req` stays high for exactly PULSE_TICKS ticks. It falls on the edge that samples the PULSE_TICKS-th tick counted after it rose. The timeout count is held at zero while the request is high.
- R3: After a reset pulse ends, the watchdog re-arms with a fresh count. The next expiry needs another full TIMEOUT_TICKS ticks.
- R4: A high-to-low transition on `strobe_n` restarts the timeout count from zero. The transition is seen after two synchronizer flops and one edge flop, so it takes effect on the third clock edge after the pin changes.
- R5: A low-to-high transition on `strobe_n` does not change the count.
- R6: While `reset_active` is 1, the count is held at zero and no new request starts. Timing starts fresh when it returns to 0.
- R7: With `mode_cmos`=1, `early_low`=1 disables the watchdog: the count is held at zero and no new request starts. Timing starts fresh when `early_low` clears.
- R8: With `mode_cmos`=0, `early_low` has no effect on the watchdog.
- R9: `supply_low`=1 disables the watchdog in either mode.
- R10: `strobe_float`=1 disables the watchdog.
- R11: A request that has started runs for its full PULSE_TICKS length, even if a disable condition appears during it.
- R12: When a strobe falling edge and a tick land on the same clock edge, the restart wins. A full TIMEOUT_TICKS ticks then follow before expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| strobe_n | input | 1 | Asynchronous software strobe; its falling edges restart the count |
| reset_active | input | 1 | System reset is currently asserted |
| mode_cmos | input | 1 | 1: the early-warning sense gates the watchdog; 0: the sense is ignored |
| early_low | input | 1 | Early-warning sense is below its threshold |
| supply_low | input | 1 | Supply is at or below its trip point |
| strobe_float | input | 1 | Strobe input is left open; disables the watchdog |
| wd_rst_req | output | 1 | Registered reset request pulse |

## Verification
The assertions assume that `tick_ms` is a single-cycle pulse and that `reset_active`, `mode_cmos`, `early_low`, `supply_low` and `strobe_float` change only between clock edges. The stimulus meets this by driving every input on the falling clock edge. Ticks are spaced at least two cycles apart. Each strobe level is held for four cycles, so the synchronizer always sees a clean edge. The bench uses a small configuration (timeout of 6 ticks, pulse of 3). It sweeps the strobe restart over every count position and checks each expiry and pulse end against tick counts it computes itself.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  // Width of a counter that must hold values 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Decision of the gating logic for one cycle
  typedef struct packed {
    logic enabled;   // no disable condition present
    logic run;       // count may advance this cycle
  } wdg_gate_t;

endpackage

// File: rtl/wdg_strobe_sync.sv
module wdg_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic fall
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  // Synchronizer chain, idle level high
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b1;
          else     chain_q[0] <= strobe_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b1;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b1;
    else     last_q <= chain_q[STAGES-1];
  end

  assign fall = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/wdg_gate.sv
module wdg_gate
  import wdg_pkg::*;
(
  input  logic      reset_active,
  input  logic      mode_cmos,
  input  logic      early_low,
  input  logic      supply_low,
  input  logic      strobe_float,
  input  logic      pulse_busy,
  output wdg_gate_t gate
);

  logic sense_block;

  always_comb begin
    // early-warning sense matters only in the low-power mode
    sense_block  = mode_cmos & early_low;
    gate.enabled = ~(supply_low | strobe_float | sense_block);
    gate.run     = gate.enabled & ~reset_active & ~pulse_busy;
  end

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer #(
  parameter int unsigned TIMEOUT_TICKS = 400,
  localparam int unsigned CW = wdg_pkg::cnt_width(TIMEOUT_TICKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          restart,
  input  logic          tick,
  output logic          expire,
  output logic [CW-1:0] count_q
);

  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

  logic at_last;

  assign at_last = (count_q == LAST);
  assign expire  = run & ~restart & tick & at_last;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      count_q <= '0;
    end else if (restart) begin
      count_q <= '0;
    end else if (tick) begin
      count_q <= at_last ? '0 : count_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
  parameter int unsigned PULSE_TICKS = 25,
  localparam int unsigned PW = wdg_pkg::cnt_width(PULSE_TICKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic          tick,
  output logic          active_q,
  output logic [PW-1:0] count_q
);

  localparam logic [PW-1:0] LAST = PW'(PULSE_TICKS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      count_q  <= '0;
    end else if (!active_q) begin
      active_q <= fire;
      count_q  <= '0;
    end else if (tick) begin
      if (count_q == LAST) begin
        active_q <= 1'b0;
        count_q  <= '0;
      end else begin
        count_q  <= count_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog
  import wdg_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 400,
  parameter int unsigned PULSE_TICKS   = 25,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_ms,
  input  logic strobe_n,
  input  logic reset_active,
  input  logic mode_cmos,
  input  logic early_low,
  input  logic supply_low,
  input  logic strobe_float,
  output logic wd_rst_req
);

  localparam int unsigned CW = cnt_width(TIMEOUT_TICKS);
  localparam int unsigned PW = cnt_width(PULSE_TICKS);

  logic          strobe_fall;
  logic          expire;
  logic          pulse_active;
  logic [CW-1:0] timer_count;
  logic [PW-1:0] pulse_count;
  wdg_gate_t     gate;

  wdg_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .strobe_n (strobe_n),
    .fall     (strobe_fall)
  );

  wdg_gate u_gate (
    .reset_active (reset_active),
    .mode_cmos    (mode_cmos),
    .early_low    (early_low),
    .supply_low   (supply_low),
    .strobe_float (strobe_float),
    .pulse_busy   (pulse_active),
    .gate         (gate)
  );

  wdg_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (gate.run),
    .restart (strobe_fall),
    .tick    (tick_ms),
    .expire  (expire),
    .count_q (timer_count)
  );

  wdg_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk      (clk),
    .rst      (rst),
    .fire     (expire),
    .tick     (tick_ms),
    .active_q (pulse_active),
    .count_q  (pulse_count)
  );

  assign wd_rst_req = pulse_active;

endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
  parameter int unsigned TIMEOUT_TICKS = 400,
  parameter int unsigned PULSE_TICKS   = 25,
  localparam int unsigned CW = wdg_pkg::cnt_width(TIMEOUT_TICKS),
  localparam int unsigned PW = wdg_pkg::cnt_width(PULSE_TICKS)
) (
  input logic          clk,
  input logic          rst,
  input logic          tick_ms,
  input logic          reset_active,
  input logic          mode_cmos,
  input logic          early_low,
  input logic          supply_low,
  input logic          strobe_float,
  input logic          wd_rst_req,
  input logic [CW-1:0] timer_count,
  input logic [PW-1:0] pulse_count
);

  assert_start_on_tick_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_rst_req) |-> $past(tick_ms));

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
    timer_count < CW'(TIMEOUT_TICKS));

  assert_end_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(wd_rst_req) |-> $past(tick_ms));

  assert_frozen_in_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    wd_rst_req |-> timer_count == '0);

  assert_pulse_bound_R2: assert property (@(posedge clk) disable iff (rst)
    pulse_count < PW'(PULSE_TICKS));

  assert_hold_in_reset_R6: assert property (@(posedge clk) disable iff (rst)
    reset_active && !wd_rst_req |=> !wd_rst_req);

  assert_sense_gate_R7: assert property (@(posedge clk) disable iff (rst)
    mode_cmos && early_low && !wd_rst_req |=> !wd_rst_req);

  assert_supply_gate_R9: assert property (@(posedge clk) disable iff (rst)
    supply_low && !wd_rst_req |=> !wd_rst_req);

  assert_float_gate_R10: assert property (@(posedge clk) disable iff (rst)
    strobe_float && !wd_rst_req |=> !wd_rst_req);

  assert_pulse_completes_R11: assert property (@(posedge clk) disable iff (rst)
    wd_rst_req && !tick_ms |=> wd_rst_req);

endmodule

bind strobe_watchdog wdg_checker #(
  .TIMEOUT_TICKS (TIMEOUT_TICKS),
  .PULSE_TICKS   (PULSE_TICKS)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .tick_ms      (tick_ms),
  .reset_active (reset_active),
  .mode_cmos    (mode_cmos),
  .early_low    (early_low),
  .supply_low   (supply_low),
  .strobe_float (strobe_float),
  .wd_rst_req   (wd_rst_req),
  .timer_count  (u_timer.count_q),
  .pulse_count  (u_pulse.count_q)
);

// File: tb/test_strobe_watchdog.sv
module test_strobe_watchdog;

  localparam int TO = 6;
  localparam int PU = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_ms = 1'b0;
  logic strobe_n = 1'b1;
  logic reset_active = 1'b0;
  logic mode_cmos = 1'b0;
  logic early_low = 1'b0;
  logic supply_low = 1'b0;
  logic strobe_float = 1'b0;
  logic wd_rst_req;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  strobe_watchdog #(.TIMEOUT_TICKS(TO), .PULSE_TICKS(PU)) i_strobe_watchdog (
    .clk          (clk),
    .rst          (rst),
    .tick_ms      (tick_ms),
    .strobe_n     (strobe_n),
    .reset_active (reset_active),
    .mode_cmos    (mode_cmos),
    .early_low    (early_low),
    .supply_low   (supply_low),
    .strobe_float (strobe_float),
    .wd_rst_req   (wd_rst_req)
  );

  task automatic chk(input string tag, input logic exp);
    checks++;
    if (wd_rst_req !== exp) begin
      fails++;
      $display("FAIL %s: wd_rst_req=%0b expected %0b", tag, wd_rst_req, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_ms = 1'b1;
      @(negedge clk) tick_ms = 1'b0;
    end
  endtask

  task automatic strobe_to(input logic v);
    @(negedge clk) strobe_n = v;
    repeat (4) @(negedge clk);
  endtask

  // From a fresh count: expiry on the TO-th tick, pulse of PU ticks
  task automatic expect_expiry(input string tag);
    ticks(TO - 1);
    chk(tag, 1'b0);
    ticks(1);
    chk(tag, 1'b1);
    ticks(PU - 1);
    chk({tag, " R2 hold"}, 1'b1);
    ticks(1);
    chk({tag, " R2 end"}, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, got running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("reset", 1'b0);

    // R1, R2: plain expiry and pulse length
    expect_expiry("R1");
    // R3: re-arm after the pulse with a fresh count
    expect_expiry("R3");

    // R4: restart swept over every count position
    for (int k = 1; k < TO; k++) begin
      ticks(k);
      strobe_to(1'b0);
      strobe_to(1'b1);
      expect_expiry($sformatf("R4 k=%0d", k));
    end

    // R5: a rising edge mid-count does not restart
    strobe_to(1'b0);
    ticks(2);
    strobe_to(1'b1);
    ticks(TO - 3);
    chk("R5 before", 1'b0);
    ticks(1);
    chk("R5 expiry", 1'b1);
    ticks(PU);
    chk("R5 end", 1'b0);

    // R12: fall and tick on the same edge; restart wins
    ticks(3);
    @(negedge clk) strobe_n = 1'b0;
    @(negedge clk);
    @(negedge clk) tick_ms = 1'b1;
    @(negedge clk) tick_ms = 1'b0;
    strobe_to(1'b1);
    expect_expiry("R12");

    // R6: system reset holds the count, timing starts fresh
    ticks(3);
    @(negedge clk) reset_active = 1'b1;
    ticks(2 * TO);
    chk("R6 held", 1'b0);
    @(negedge clk) reset_active = 1'b0;
    expect_expiry("R6");

    // R7: low-power mode with early warning low disables
    @(negedge clk) mode_cmos = 1'b1;
    ticks(3);
    @(negedge clk) early_low = 1'b1;
    ticks(2 * TO);
    chk("R7 held", 1'b0);
    @(negedge clk) early_low = 1'b0;
    expect_expiry("R7");

    // R8: other mode ignores the early warning
    @(negedge clk) begin mode_cmos = 1'b0; early_low = 1'b1; end
    expect_expiry("R8");
    @(negedge clk) early_low = 1'b0;

    // R9: supply low disables in both modes
    for (int m = 0; m < 2; m++) begin
      @(negedge clk) mode_cmos = logic'(m);
      ticks(2);
      @(negedge clk) supply_low = 1'b1;
      ticks(2 * TO);
      chk($sformatf("R9 mode=%0d held", m), 1'b0);
      @(negedge clk) supply_low = 1'b0;
      expect_expiry($sformatf("R9 mode=%0d", m));
    end
    @(negedge clk) mode_cmos = 1'b0;

    // R10: floating strobe indication disables
    ticks(4);
    @(negedge clk) strobe_float = 1'b1;
    ticks(2 * TO);
    chk("R10 held", 1'b0);
    @(negedge clk) strobe_float = 1'b0;
    expect_expiry("R10");

    // R11: disable during a pulse does not cut it short
    ticks(TO);
    chk("R11 start", 1'b1);
    @(negedge clk) supply_low = 1'b1;
    ticks(PU - 1);
    chk("R11 full length", 1'b1);
    ticks(1);
    chk("R11 end", 1'b0);
    ticks(2 * TO);
    chk("R11 no new request", 1'b0);
    @(negedge clk) supply_low = 1'b0;
    expect_expiry("R11 recover");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule